// File: doc/BRIEF.md
# Sector Write-Protection Gate

This block sits in front of a small data-flash array and decides, for every write or erase request, whether the addressed sector may be touched. Two registered security vectors drive the decision. A global vector carries a master protection-enable bit. A 16-bit per-sector vector holds one active-low protect bit for each sector position. Both vectors are loaded together through a parallel load port with a one-cycle strobe.

The decision is combinational from the registered vectors and the live request. A request that is allowed raises the write strobe in the same cycle. A request that is refused raises a one-cycle error pulse instead. Only five vector positions correspond to real sectors: four main data sectors and the sector that stores the security vectors. A request to any other index is always refused.

After reset the block is fully closed. The master enable is on and every sector bit reads as protected, so nothing can be written until software loads the vectors.

Top module: `prot_gate`

## Requirements
- R1: After reset, with no vector load yet, a request to any sector index 0 to 15 gives error high and grant low.
- R2: When bit 1 of the global vector is 0, every request to an implemented sector gives grant high and error low, whatever the sector vector holds.
- R3: When bit 1 of the global vector is 1, a request to implemented sector index i gives grant when sector-vector bit i is 1, and gives error when that bit is 0.
- R4: The sector index equals the sector-vector bit position. The implemented indices are 0, 1, 2 and 3 (main sectors) and 8 (the sector holding the vectors).
- R5: A request to index 4 to 7 or 9 to 15 gives error high and grant low, for every vector content.
- R6: Sector-vector bits 7:4 and 15:9 do not change the outcome of any request to an implemented sector.
- R7: Grant and error are never high together. Both are low in every cycle where request-valid is low.
- R8: Values on the load inputs take effect from the cycle after a cycle with the load strobe high. Without the strobe, the stored vectors keep their values.
- R9: Global-vector bits other than bit 1 do not change any outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vec_load | input | 1 | Load strobe for both vectors |
| vec_global_in | input | 8 | Global vector value to load (bit 1 = protection enable) |
| vec_sector_in | input | 16 | Per-sector vector value to load (0 = protected) |
| req_valid | input | 1 | Write/erase request present this cycle |
| req_sector | input | 4 | Target sector index (vector bit position) |
| wr_grant | output | 1 | Request allowed; write strobe to the array |
| wr_error | output | 1 | Request refused; one-cycle error pulse |

## Verification
The bench sweeps all 16 indices against many vector pairs: a cleared and a set enable bit, the enable bit mixed with noise in the other global bits, walking ones and walking zeros, and noise in the unmapped sector bits. A design with the protect polarity inverted would grant exactly the sectors it should block. A design that ignored the master enable would block when the enable is clear. A design that decoded the unmapped positions would grant indices such as 4 or 12 once their bits were set. A design that loaded the vectors one cycle late, or reset them open, would fail the reset and load-timing checks.

// File: rtl/prot_pkg.sv
// Package: shared sizes and the map of implemented sectors for the
// write-protection gate. Assumes the sector index is a vector bit position.
package prot_pkg;
    localparam int GLB_W     = 8;           // global vector width
    localparam int SEC_W     = 16;          // per-sector vector width
    localparam int EN_BIT    = 1;           // master enable position
    localparam int IDX_W     = $clog2(SEC_W);
    // positions 0..3 are main sectors, 8 holds the vectors
    localparam logic [SEC_W-1:0] IMPL_MASK = 16'h010F;
    // reset contents: enable on, every sector protected
    localparam logic [GLB_W-1:0] GLB_RST = GLB_W'(1) << EN_BIT;
    localparam logic [SEC_W-1:0] SEC_RST = '0;
endpackage

// File: rtl/prot_vec_regs.sv
// Holds the global and per-sector security vectors.
// Assumes loads are single-cycle strobes; reset closes all sectors.
module prot_vec_regs
    import prot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GLB_W-1:0] glb_in,
    input  logic [SEC_W-1:0] sec_in,
    output logic [GLB_W-1:0] glb_q,
    output logic [SEC_W-1:0] sec_q
);
    // Capture both vectors on the strobe; reset to the closed state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_q <= GLB_RST;
            sec_q <= SEC_RST;
        end else if (load) begin
            glb_q <= glb_in;
            sec_q <= sec_in;
        end
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(sec_q) && $stable(glb_q)));
    assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sec_q == $past(sec_in) && glb_q == $past(glb_in)));
endmodule

// File: rtl/prot_sector_map.sv
// Turns the stored vectors into one "writable" flag per index.
// Assumes bit positions outside IMPL_MASK name no sector.
module prot_sector_map
    import prot_pkg::*;
(
    input  logic [GLB_W-1:0] glb_q,
    input  logic [SEC_W-1:0] sec_q,
    output logic [SEC_W-1:0] open_vec
);
    logic enable;

    // Master protection enable from the global vector.
    always_comb enable = glb_q[EN_BIT];

    for (genvar i = 0; i < SEC_W; i++) begin : g_slot
        if (IMPL_MASK[i]) begin : g_real
            // Real sector: open when protection is off or its bit is 1.
            always_comb open_vec[i] = !enable || sec_q[i];
        end else begin : g_none
            // No sector here: never open.
            always_comb open_vec[i] = 1'b0;
        end
    end

    always_comb begin
        assert_unmapped_closed_R5: assert ((open_vec & ~IMPL_MASK) == '0);
    end
endmodule

// File: rtl/prot_gate.sv
// Top: grants or refuses flash write/erase requests per sector.
// Assumes one request per valid cycle; decision is combinational
// from the registered vectors, errors are one pulse per refused cycle.
module prot_gate
    import prot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vec_load,
    input  logic [7:0]       vec_global_in,
    input  logic [15:0]      vec_sector_in,
    input  logic             req_valid,
    input  logic [3:0]       req_sector,
    output logic             wr_grant,
    output logic             wr_error
);
    logic [GLB_W-1:0] glb_q;
    logic [SEC_W-1:0] sec_q;
    logic [SEC_W-1:0] open_vec;
    logic             slot_open;

    prot_vec_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (vec_load),
        .glb_in (vec_global_in),
        .sec_in (vec_sector_in),
        .glb_q  (glb_q),
        .sec_q  (sec_q)
    );

    prot_sector_map u_map (
        .glb_q    (glb_q),
        .sec_q    (sec_q),
        .open_vec (open_vec)
    );

    // Pick the flag of the addressed index.
    always_comb slot_open = open_vec[req_sector];

    // Split a valid request into grant or error.
    always_comb begin
        wr_grant = req_valid && slot_open;
        wr_error = req_valid && !slot_open;
    end

    assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_grant && wr_error));
    assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!wr_grant && !wr_error));
    assert_unmapped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_sector inside {[4'd4:4'd7], [4'd9:4'd15]}))
        |-> (wr_error && !wr_grant));
    assert_answer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (wr_grant || wr_error));
endmodule

// File: tb/sim_prot_gate.sv
// Bench: sweeps indices against many vector pairs, expected values
// computed from the requirements.
module sim_prot_gate;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vec_load = 1'b0;
    logic [7:0]  vec_global_in = '0;
    logic [15:0] vec_sector_in = '0;
    logic req_valid = 1'b0;
    logic [3:0] req_sector = '0;
    logic wr_grant, wr_error;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    prot_gate u0 (.*);

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    function automatic bit is_real(input int idx);
        return (idx <= 3) || (idx == 8);
    endfunction

    task automatic load(input logic [7:0] g, input logic [15:0] s);
        @(negedge clk);
        vec_global_in = g; vec_sector_in = s; vec_load = 1'b1;
        @(negedge clk);
        vec_load = 1'b0;
        vec_global_in = ~g; vec_sector_in = ~s; // noise, must not be captured
    endtask

    // Sweep all indices under stored vectors g/s; tag names the requirement.
    task automatic sweep(input logic [7:0] g, input logic [15:0] s, input string tag);
        for (int i = 0; i < 16; i++) begin
            bit exp_g;
            req_valid = 1'b1; req_sector = 4'(i);
            #2;
            exp_g = is_real(i) && (!g[1] || s[i]);
            check(is_real(i) ? tag : "R5", wr_grant, exp_g, $sformatf("grant idx=%0d", i));
            check(is_real(i) ? tag : "R5", wr_error, !exp_g, $sformatf("error idx=%0d", i));
            @(negedge clk);
        end
        req_valid = 1'b0;
        #2;
        check("R7", wr_grant, 1'b0, "grant idle");
        check("R7", wr_error, 1'b0, "error idle");
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: closed after reset
        sweep(8'h02, 16'h0000, "R1");
        // R2: enable clear opens all real sectors
        load(8'h00, 16'h0000); sweep(8'h00, 16'h0000, "R2");
        load(8'hFD, 16'h0000); sweep(8'hFD, 16'h0000, "R9");
        // R3 and R4: walking ones and zeros with enable set
        for (int b = 0; b < 16; b++) begin
            load(8'h02, 16'(1) << b); sweep(8'h02, 16'(1) << b, "R3");
            load(8'h02, ~(16'(1) << b)); sweep(8'h02, ~(16'(1) << b), "R4");
        end
        // R6: unmapped bits set to noise around fixed real bits
        load(8'h02, 16'hFEF0); sweep(8'h02, 16'hFEF0, "R6");
        load(8'h02, 16'h0105); sweep(8'h02, 16'h0105, "R6");
        load(8'h02, 16'hFFFF); sweep(8'h02, 16'hFFFF, "R6");
        // R9: other global bits do not matter
        load(8'hFF, 16'h0103); sweep(8'hFF, 16'h0103, "R9");
        load(8'h00, 16'h5A5A); sweep(8'h00, 16'h5A5A, "R9");
        // R8: strobe timing; drive load and sample before and after edge
        load(8'h02, 16'h0000);
        vec_global_in = 8'h02; vec_sector_in = 16'h0001; vec_load = 1'b1;
        req_valid = 1'b1; req_sector = 4'd0;
        #2;
        check("R8", wr_grant, 1'b0, "before capture edge");
        @(negedge clk);
        vec_load = 1'b0; vec_sector_in = 16'h0000;
        #2;
        check("R8", wr_grant, 1'b1, "after capture edge");
        @(negedge clk);
        check("R8", wr_grant, 1'b1, "held without strobe");
        req_valid = 1'b0;
        // R1: reset again closes
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        sweep(8'h02, 16'h0000, "R1");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule